// File: doc/BRIEF.md
# Fuse Array Read Sequencer

This block reads a byte range out of a one-time-programmable fuse macro that holds 32 words of 32 bits (128 bytes). A client gives a byte offset and a byte length with a one-cycle start pulse. The sequencer then drives the macro's control word through a fixed order of pin states. It holds each state for a timed interval of at least 1 µs and captures the macro's 32-bit data output once per word. The bytes it returns go out as a valid/ready byte stream.

The byte range is turned into a span of word addresses. The start word is the offset divided by four, and the span stops at the end of the array. Bytes are taken least significant first, beginning at the offset's position within the first word. When the last word has been read and its gap has elapsed, the macro goes back to standby. A done pulse then reports how many bytes were returned. A request that cannot return any byte finishes at once with an error flag and leaves the macro pins alone.

Top module: `fuse_rd_seq`

## Requirements
- R1: After reset and whenever no session is active, `fz_ctrl` equals 0x0000_0021: power-down (bit 5) and chip-select-bar (bit 0) high, every other bit low.
- R2: A session opens by driving `fz_ctrl` to 0x0000_028C: load (bit 2), program-enable-bar (bit 3), sense select (bit 7) and strobe-shift select (bit 9) high, address bits 25:16 zero. This value is held for exactly HOLD cycles before the first strobe, where HOLD = ceil(CLK_FREQ_HZ × 1 µs), which is 50 at 50 MHz.
- R3: Each word access raises strobe (bit 1), with the word address in bits 25:16 and the other read-mode bits unchanged. Strobe stays high for exactly HOLD cycles, and `fz_dout` is captured at the end of that interval.
- R4: After strobe falls, it stays low for at least HOLD cycles before the next strobe. The address field stays constant while strobe is high.
- R5: The first word accessed is offset/4. Later words follow in ascending order, and no address is 32 or above.
- R6: Output bytes are the array bytes offset, offset+1, and so on, in that order. Array byte 4·w+k is bits 8k+7:8k of word w, and the stream starts at byte offset mod 4 within the first word.
- R7: The number of bytes emitted, which is also the value on `req_count` during `req_done`, is min(length, 128 − offset).
- R8: If length is 0 or offset is 128 or more, `req_done` and `req_err` are high in the cycle after the start edge. In that case `req_count` is 0, `req_busy` stays low, no byte is emitted and `fz_ctrl` remains at standby.
- R9: While `out_valid` is high and `out_ready` is low, `out_data` holds its value. During such a stall the macro stays in read mode with strobe low.
- R10: `req_busy` is high from the cycle after an accepted start until done. A start pulse seen while busy is ignored.
- R11: `req_done` is a one-cycle pulse. `fz_ctrl` returns to standby in the same cycle that `req_done` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_start | input | 1 | One-cycle request pulse |
| req_offset | input | LEN_W | Starting byte offset |
| req_len | input | LEN_W | Requested byte count |
| req_busy | output | 1 | Session in progress |
| req_done | output | 1 | One-cycle completion pulse |
| req_err | output | 1 | Request rejected (valid with done) |
| req_count | output | LEN_W | Bytes returned (valid with done) |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Consumer accepts byte |
| out_data | output | 8 | Output byte |
| fz_ctrl | output | 32 | Fuse macro control word |
| fz_dout | input | WORD_BITS | Fuse macro data output |

## Verification
A rejected request is due at the first falling edge after the start edge, and the bench samples done, error and count at exactly that edge. In an accepted session the setup state lasts exactly HOLD cycles, and the monitor measures this by counting falling edges in each control state. It checks the same count on each strobe-high interval, and it requires the strobe-low gap to last at least HOLD cycles. The byte stream is not checked against fixed cycles. Each handshake is paired with the next queued expected byte, and the count is checked on the falling edge where done is first seen.

// File: rtl/fuse_rd_pkg.sv
package fuse_rd_pkg;

  localparam int CTL_W      = 32;
  localparam int B_CSN      = 0;
  localparam int B_STB      = 1;
  localparam int B_LOAD     = 2;
  localparam int B_PGMN     = 3;
  localparam int B_PWRDN    = 5;
  localparam int B_SENSE    = 7;
  localparam int B_SSEL     = 9;
  localparam int B_ADDR     = 16;
  localparam int ADDR_FLD_W = 10;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STRB,
    ST_EMIT,
    ST_GAP
  } seq_st_t;

  function automatic logic [CTL_W-1:0] ctl_standby();
    logic [CTL_W-1:0] w;
    w          = '0;
    w[B_PWRDN] = 1'b1;
    w[B_CSN]   = 1'b1;
    return w;
  endfunction

  function automatic logic [CTL_W-1:0] ctl_read(input logic stb,
                                                input logic [ADDR_FLD_W-1:0] a);
    logic [CTL_W-1:0] w;
    w                        = '0;
    w[B_LOAD]                = 1'b1;
    w[B_PGMN]                = 1'b1;
    w[B_SENSE]               = 1'b1;
    w[B_SSEL]                = 1'b1;
    w[B_STB]                 = stb;
    w[B_ADDR +: ADDR_FLD_W]  = a;
    return w;
  endfunction

endpackage

// File: rtl/fuse_span_calc.sv
module fuse_span_calc #(
  parameter int WORDS = 32,
  parameter int BPW   = 4,
  parameter int LEN_W = 8
) (
  input  logic [LEN_W-1:0]         off,
  input  logic [LEN_W-1:0]         len,
  output logic                     bad,
  output logic [$clog2(WORDS)-1:0] first,
  output logic [$clog2(BPW)-1:0]   skip,
  output logic [LEN_W-1:0]         nbytes
);
  localparam int AW    = $clog2(WORDS);
  localparam int SKW   = $clog2(BPW);
  localparam int TOTAL = WORDS * BPW;

  logic [LEN_W-1:0] avail;

  always_comb begin
    bad    = (len == '0) || (off >= LEN_W'(TOTAL));
    avail  = LEN_W'(TOTAL) - off;
    nbytes = (len < avail) ? len : avail;
    first  = off[SKW +: AW];
    skip   = off[SKW-1:0];
  end
endmodule

// File: rtl/fuse_hold_timer.sv
module fuse_hold_timer #(
  parameter int CLK_FREQ_HZ = 50_000_000,
  parameter int HOLD_NS     = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic kick,
  output logic expired
);
  localparam longint PROD     = longint'(CLK_FREQ_HZ) * longint'(HOLD_NS);
  localparam longint RAW      = (PROD + 64'sd999_999_999) / 64'sd1_000_000_000;
  localparam int     HOLD_CYC = (RAW < 1) ? 1 : int'(RAW);
  localparam int     TW       = $clog2(HOLD_CYC + 1);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (kick)        cnt <= TW'(HOLD_CYC - 1);
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/fuse_rd_seq.sv
module fuse_rd_seq #(
  parameter int CLK_FREQ_HZ = 50_000_000,
  parameter int HOLD_NS     = 1000,
  parameter int WORDS       = 32,
  parameter int WORD_BITS   = 32,
  parameter int LEN_W       = $clog2(WORDS * WORD_BITS / 8) + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_start,
  input  logic [LEN_W-1:0]     req_offset,
  input  logic [LEN_W-1:0]     req_len,
  output logic                 req_busy,
  output logic                 req_done,
  output logic                 req_err,
  output logic [LEN_W-1:0]     req_count,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [7:0]           out_data,
  output logic [31:0]          fz_ctrl,
  input  logic [WORD_BITS-1:0] fz_dout
);
  import fuse_rd_pkg::*;

  localparam int BPW = WORD_BITS / 8;
  localparam int AW  = $clog2(WORDS);
  localparam int SKW = $clog2(BPW);
  localparam logic [SKW-1:0] LAST_B = SKW'(BPW - 1);

  seq_st_t               st;
  logic [WORD_BITS-1:0]  word_q;
  logic [SKW-1:0]        bidx;
  logic [AW-1:0]         waddr;
  logic [LEN_W-1:0]      rem;
  logic [LEN_W-1:0]      sent;

  logic                  sp_bad;
  logic [AW-1:0]         sp_first;
  logic [SKW-1:0]        sp_skip;
  logic [LEN_W-1:0]      sp_nbytes;

  logic                  tmr_kick;
  logic                  tmr_exp;
  logic                  last_of_word;
  logic                  take;

  fuse_span_calc #(.WORDS(WORDS), .BPW(BPW), .LEN_W(LEN_W)) u_span (
    .off    (req_offset),
    .len    (req_len),
    .bad    (sp_bad),
    .first  (sp_first),
    .skip   (sp_skip),
    .nbytes (sp_nbytes)
  );

  fuse_hold_timer #(.CLK_FREQ_HZ(CLK_FREQ_HZ), .HOLD_NS(HOLD_NS)) u_tmr (
    .clk     (clk),
    .rst     (rst),
    .kick    (tmr_kick),
    .expired (tmr_exp)
  );

  always_comb begin
    take         = (st == ST_EMIT) && out_ready;
    last_of_word = (bidx == LAST_B) || (rem == LEN_W'(1));
    tmr_kick     = ((st == ST_IDLE)  && req_start && !sp_bad) ||
                   ((st == ST_SETUP) && tmr_exp) ||
                   (take && last_of_word) ||
                   ((st == ST_GAP)   && tmr_exp && (rem != '0));
  end

  assign out_data = word_q[{bidx, 3'b000} +: 8];

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      fz_ctrl   <= ctl_standby();
      req_busy  <= 1'b0;
      req_done  <= 1'b0;
      req_err   <= 1'b0;
      req_count <= '0;
      out_valid <= 1'b0;
      word_q    <= '0;
      bidx      <= '0;
      waddr     <= '0;
      rem       <= '0;
      sent      <= '0;
    end else begin
      req_done <= 1'b0;
      req_err  <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (req_start) begin
            if (sp_bad) begin
              req_done  <= 1'b1;
              req_err   <= 1'b1;
              req_count <= '0;
            end else begin
              st       <= ST_SETUP;
              req_busy <= 1'b1;
              fz_ctrl  <= ctl_read(1'b0, '0);
              waddr    <= sp_first;
              bidx     <= sp_skip;
              rem      <= sp_nbytes;
              sent     <= '0;
            end
          end
        end
        ST_SETUP: begin
          if (tmr_exp) begin
            st      <= ST_STRB;
            fz_ctrl <= ctl_read(1'b1, ADDR_FLD_W'(waddr));
          end
        end
        ST_STRB: begin
          if (tmr_exp) begin
            st        <= ST_EMIT;
            word_q    <= fz_dout;
            fz_ctrl   <= ctl_read(1'b0, ADDR_FLD_W'(waddr));
            out_valid <= 1'b1;
          end
        end
        ST_EMIT: begin
          if (out_ready) begin
            sent <= sent + 1'b1;
            rem  <= rem - 1'b1;
            if (last_of_word) begin
              out_valid <= 1'b0;
              st        <= ST_GAP;
            end else begin
              bidx <= bidx + 1'b1;
            end
          end
        end
        ST_GAP: begin
          if (tmr_exp) begin
            if (rem == '0) begin
              st        <= ST_IDLE;
              fz_ctrl   <= ctl_standby();
              req_busy  <= 1'b0;
              req_done  <= 1'b1;
              req_count <= sent;
            end else begin
              st      <= ST_STRB;
              waddr   <= waddr + 1'b1;
              bidx    <= '0;
              fz_ctrl <= ctl_read(1'b1, ADDR_FLD_W'(waddr + 1'b1));
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fuse_rd_seq_chk.sv
module fuse_rd_seq_chk #(
  parameter int WORDS = 32
) (
  input logic        clk,
  input logic        rst,
  input logic        req_busy,
  input logic        req_done,
  input logic        req_err,
  input logic        out_valid,
  input logic        out_ready,
  input logic [7:0]  out_data,
  input logic [31:0] fz_ctrl
);
  // R1
  idle_standby_chk: assert property (@(posedge clk) disable iff (rst)
    !req_busy |-> (fz_ctrl == 32'h0000_0021));

  // R3
  strobe_mode_chk: assert property (@(posedge clk) disable iff (rst)
    fz_ctrl[1] |-> (fz_ctrl[2] && fz_ctrl[3] && !fz_ctrl[0] && !fz_ctrl[5]));

  // R4
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (fz_ctrl[1] && $past(fz_ctrl[1])) |-> $stable(fz_ctrl[25:16]));

  // R5
  addr_range_chk: assert property (@(posedge clk) disable iff (rst)
    fz_ctrl[1] |-> (fz_ctrl[25:16] < 10'(WORDS)));

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R9
  stall_mode_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (fz_ctrl[2] && !fz_ctrl[1]));

  // R10
  valid_in_session_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> req_busy);

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    req_done |=> !req_done);

  // R8
  err_with_done_chk: assert property (@(posedge clk) disable iff (rst)
    req_err |-> req_done);
endmodule

bind fuse_rd_seq fuse_rd_seq_chk #(.WORDS(WORDS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_busy  (req_busy),
  .req_done  (req_done),
  .req_err   (req_err),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .fz_ctrl   (fz_ctrl)
);

// File: tb/sim_fuse_rd_seq.sv
module sim_fuse_rd_seq;
  localparam int HOLD  = 50;
  localparam int LEN_W = 8;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             req_start = 1'b0;
  logic [LEN_W-1:0] req_offset = '0;
  logic [LEN_W-1:0] req_len = '0;
  logic             req_busy, req_done, req_err;
  logic [LEN_W-1:0] req_count;
  logic             out_valid;
  logic             out_ready = 1'b1;
  logic [7:0]       out_data;
  logic [31:0]      fz_ctrl;
  logic [31:0]      fz_dout;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  logic [7:0] exp_q[$];
  bit  bp_on = 0;
  int  bp_cnt = 0;
  bit  prev_stall = 0;
  logic [7:0] prev_data = '0;

  bit  first_strobe = 0;
  int  exp_addr = 0;
  int  setup_cnt = 0;
  int  hi_cnt = 0;
  int  lo_cnt = 0;
  bit  prev_stb = 0;

  always #10 clk = ~clk;

  fuse_rd_seq u0 (
    .clk(clk), .rst(rst), .req_start(req_start), .req_offset(req_offset),
    .req_len(req_len), .req_busy(req_busy), .req_done(req_done),
    .req_err(req_err), .req_count(req_count), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .fz_ctrl(fz_ctrl),
    .fz_dout(fz_dout)
  );

  function automatic logic [7:0] byte_at(input int k);
    return 8'((k * 37 + 11) & 255);
  endfunction

  function automatic logic [31:0] word_at(input int w);
    return {byte_at(4*w+3), byte_at(4*w+2), byte_at(4*w+1), byte_at(4*w)};
  endfunction

  // behavioural fuse macro
  assign fz_dout = (fz_ctrl[1] && fz_ctrl[2] && fz_ctrl[3] && !fz_ctrl[0] && !fz_ctrl[5])
                   ? word_at(int'(fz_ctrl[25:16])) : 32'hDEAD_BEEF;

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // pin monitor: timing and address order
  always @(negedge clk) begin
    if (!rst) begin
      if (first_strobe && fz_ctrl == 32'h0000_028C) setup_cnt++;
      if (fz_ctrl[1] && !prev_stb) begin
        if (first_strobe) begin
          chk(setup_cnt == HOLD, "R2 setup hold", setup_cnt, HOLD);
          first_strobe = 0;
        end else begin
          chk(lo_cnt >= HOLD, "R4 strobe gap", lo_cnt, HOLD);
        end
        chk(fz_ctrl == (32'h0000_028E | (32'(exp_addr) << 16)), "R3/R5 strobe word",
            fz_ctrl, 32'h0000_028E | (32'(exp_addr) << 16));
        exp_addr++;
        hi_cnt = 1;
      end else if (fz_ctrl[1]) begin
        hi_cnt++;
      end else if (!fz_ctrl[1] && prev_stb) begin
        chk(hi_cnt == HOLD, "R3 strobe width", hi_cnt, HOLD);
        lo_cnt = 1;
      end else begin
        lo_cnt++;
      end
      prev_stb = fz_ctrl[1];
    end
  end

  // ready driver + scoreboard monitor
  always @(negedge clk) begin
    bp_cnt++;
    out_ready = !bp_on || ((bp_cnt % 4) == 3);
    if (!rst && out_valid) begin
      if (prev_stall)
        chk(out_data == prev_data, "R9 stall data", out_data, prev_data);
      if (out_ready) begin
        if (exp_q.size() == 0) begin
          chk(0, "R7 extra byte", out_data, 0);
        end else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(out_data == e, "R6 byte", out_data, e);
        end
        prev_stall = 0;
      end else begin
        chk(fz_ctrl[2] && !fz_ctrl[1] && !fz_ctrl[0], "R9 stall mode", fz_ctrl, 32'h0000_028C);
        prev_stall = 1;
        prev_data  = out_data;
      end
    end else begin
      prev_stall = 0;
    end
  end

  task automatic run_req(input int off, input int len, input bit bp, input bit poke);
    int  n;
    bit  rej;
    bit  seen;
    rej = (len == 0) || (off >= 128);
    n   = rej ? 0 : ((len < 128 - off) ? len : 128 - off);
    for (int j = 0; j < n; j++) exp_q.push_back(byte_at(off + j));
    @(negedge clk);
    bp_on        = bp;
    exp_addr     = off / 4;
    first_strobe = !rej;
    setup_cnt    = 0;
    req_offset   = LEN_W'(off);
    req_len      = LEN_W'(len);
    req_start    = 1'b1;
    @(negedge clk);
    req_start = 1'b0;
    if (rej) begin
      chk(req_done && req_err, "R8 reject done/err", {req_done, req_err}, 2'b11);
      chk(req_count == 0, "R8 reject count", req_count, 0);
      chk(!req_busy, "R8 reject busy", req_busy, 0);
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        chk(fz_ctrl == 32'h0000_0021 && !out_valid, "R8 pins untouched", fz_ctrl, 32'h21);
      end
    end else begin
      chk(req_busy, "R10 busy after start", req_busy, 1);
      if (poke) begin
        req_offset = 8'd0;
        req_len    = 8'd4;
        req_start  = 1'b1;
        @(negedge clk);
        req_start  = 1'b0;
      end
      seen = 0;
      for (int k = 0; k < 20000 && !seen; k++) begin
        if (req_done) seen = 1;
        else @(negedge clk);
      end
      chk(seen, "R11 done seen", seen, 1);
      chk(req_count == LEN_W'(n), "R7 count", req_count, n);
      chk(!req_err, "R7 no error", req_err, 0);
      chk(fz_ctrl == 32'h0000_0021, "R11 standby at done", fz_ctrl, 32'h21);
      chk(!req_busy, "R10 busy cleared", req_busy, 0);
      chk(exp_q.size() == 0, "R6 all bytes", exp_q.size(), 0);
      @(negedge clk);
      chk(!req_done, "R11 done pulse", req_done, 0);
    end
    exp_q.delete();
    bp_on = 0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(fz_ctrl == 32'h0000_0021, "R1 reset ctrl", fz_ctrl, 32'h21);
    chk(!req_busy && !req_done && !out_valid, "R1 reset outputs",
        {req_busy, req_done, out_valid}, 0);
    run_req(0, 128, 0, 0);
    run_req(5, 7, 1, 1);
    run_req(126, 10, 0, 0);
    run_req(3, 1, 0, 0);
    run_req(124, 4, 1, 0);
    run_req(0, 0, 0, 0);
    run_req(128, 4, 0, 0);
    run_req(200, 1, 0, 0);
    run_req(61, 20, 1, 0);
    repeat (3) @(negedge clk);
    chk(fz_ctrl == 32'h0000_0021, "R1 idle ctrl", fz_ctrl, 32'h21);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule